// File: doc/BRIEF.md
# Non-Blocking Data Cache Miss Handler

This block is the control of a data cache that keeps serving accesses while one line is being refilled from memory. When a load or store misses, the block records the missing line, asks memory for it starting at the beat that holds the requested word, and lets issue continue. Issue is held back only in three cases. The first is an instruction that reads the register still waiting for the missed load. The second is an access that needs a second line from memory. The third is a load that touches the line being filled.

Stores that land on the line being filled are taken at once. Each one sets a bit in a per-word written mask, and that mask then blocks refill data from overwriting the store. The beat that carries the missed load's word is also sent straight to the register write path, which releases any waiting dependent in that same cycle. When the last beat has been written, the line's tag is installed, and it is marked dirty if any store touched the line. A store flagged as a block-copy store allocates its line without a memory fetch. It first writes back the victim line if that line is dirty, and then installs the new tag.

Top module: `nbmiss_handler`

## Requirements
- R1: Out of reset, the block is idle. Both stall outputs are low, and memReq, wbValid, fillWrEn, tagWrEn and victimWbEn are all low.
- R2: A lookup miss that is not a block-copy store, presented while the block is idle, raises memReq in that same cycle. memReqLine carries the lookup line, and memReqBeat carries the word index shifted right by one (the index of the 64-bit beat that holds the 32-bit word).
- R3: Lookups that hit in the cache cause no stall while a refill is in progress.
- R4: While a miss is outstanding, stallMiss is high in these cases: a lookup miss to any other line, a lookup miss arriving in the cycle of the last beat, and a load to the line being filled.
- R5: While a miss is outstanding, a store to the line being filled causes no stall and marks its 32-bit word as written.
- R6: Refill beats are accepted only while a line fill is outstanding, one beat per cycle in which fillValid is high. fillWrBeat runs through critical beat, critical+1, and so on modulo 4. fillWrData equals fillData, and fillWrLine equals the missing line. fillValid has no effect when no fill is outstanding.
- R7: fillWrMask bit j is low when word 2*beat+j was marked written. This includes a store to that word in the same cycle. Otherwise the bit is high.
- R8: stallDep is high while a missed load is outstanding and a valid source register equals its destination. In the cycle the first beat arrives, stallDep is low and wbValid is high. In that cycle wbReg is the destination and wbData is bits [31:0] of the beat for an even word or bits [63:32] for an odd word. After that beat, no dependence stall remains.
- R9: With the last beat, tagWrEn is high and tagWrLine is the missing line. tagWrDirty is high exactly when some word of the line was marked written.
- R10: A block-copy store miss raises no memReq. The next cycle, victimWbEn is high only if the victim was dirty. The cycle after that, tagWrEn is high with tagWrDirty high and the new line.
- R11: A store miss leaves no dependence stall, and hits keep flowing. A later load to the same line stalls until the line is installed.
- R12: Only one miss is outstanding at a time. After the tag is installed, the block accepts a new miss in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lkValid | input | 1 | A lookup result is presented |
| lkIsStore | input | 1 | The lookup is a store |
| lkHit | input | 1 | The tag lookup hit |
| lkBlockCopy | input | 1 | The store is a whole-line block-copy store |
| lkVictimDirty | input | 1 | The line that would be replaced is dirty |
| lkLine | input | LINE_W | Line address of the lookup |
| lkWord | input | 3 | 32-bit word index within the line |
| lkDest | input | REG_W | Destination register of a load |
| srcValid | input | NUM_SRC | Source read requests from issue |
| srcRegs | input | NUM_SRC*REG_W | Source register numbers, packed |
| fillValid | input | 1 | A refill beat is present |
| fillData | input | 64 | Refill beat data |
| stallMiss | output | 1 | Hold issue: the access needs an unavailable line |
| stallDep | output | 1 | Hold issue: a source waits for a missed load |
| memReq | output | 1 | Start a line fetch |
| memReqLine | output | LINE_W | Line to fetch |
| memReqBeat | output | 2 | First (critical) beat to return |
| wbValid | output | 1 | Early return of the requested word |
| wbReg | output | REG_W | Register receiving the early word |
| wbData | output | 32 | Early word |
| fillWrEn | output | 1 | Write a refill beat into the cache |
| fillWrLine | output | LINE_W | Line being filled |
| fillWrBeat | output | 2 | Beat index being written |
| fillWrData | output | 64 | Beat data |
| fillWrMask | output | 2 | Per-word write enables for the beat |
| tagWrEn | output | 1 | Install the tag |
| tagWrLine | output | LINE_W | Line whose tag is installed |
| tagWrDirty | output | 1 | Installed line is dirty |
| victimWbEn | output | 1 | Write the dirty victim back |

## Verification
The hardest situation to reach is a store to a word in the same cycle as the beat that carries that word, since it needs a store lookup and fillValid placed in exactly that cycle. The stimulus schedules the store for that beat. The reverse case is also hard to reach: the early-return beat must release a dependent that has already stalled for several cycles. To reach it, the stimulus holds the dependent's source request high across the gap before the critical beat. A behavioural model in the bench follows the missing line, its written words and the beat order, and it compares every output on every cycle.

// File: rtl/nbmiss_pkg.sv
package nbmiss_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_BCWB  = 2'd2,
    ST_BCTAG = 2'd3
  } mhState_t;

  // control -> datapath
  typedef struct packed {
    logic captureMiss;
    logic captureBc;
    logic markStore;
    logic beatTake;
    logic critBeat;
    logic lastBeat;
    logic bcInstall;
  } mhStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic lineMatch;
    logic depMatch;
    logic pendLoad;
    logic vicDirty;
  } mhStatus_t;

endpackage

// File: rtl/nbmiss_ctrl.sv
module nbmiss_ctrl
  import nbmiss_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic lkValid,
  input  logic lkIsStore,
  input  logic lkHit,
  input  logic lkBlockCopy,
  input  logic fillValid,
  input  mhStatus_t status,
  output mhStrobe_t strobe,
  output logic [$clog2(BEATS)-1:0] beatCnt,
  output logic stallMiss,
  output logic stallDep,
  output logic memReq,
  output logic wbValid,
  output logic fillWrEn,
  output logic tagWrEn,
  output logic victimWbEn
);

  localparam int CNT_W = $clog2(BEATS);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  mhState_t state;
  logic busy, isBc, missIn;

  always_comb begin
    busy   = (state != ST_IDLE);
    isBc   = lkIsStore & lkBlockCopy;
    missIn = lkValid & ~lkHit;

    strobe             = '0;
    strobe.captureMiss = ~busy & missIn & ~isBc;
    strobe.captureBc   = ~busy & missIn & isBc;
    strobe.markStore   = busy & lkValid & lkIsStore & status.lineMatch;
    strobe.beatTake    = (state == ST_FILL) & fillValid;
    strobe.critBeat    = strobe.beatTake & (beatCnt == '0);
    strobe.lastBeat    = strobe.beatTake & (beatCnt == LAST_BEAT);
    strobe.bcInstall   = (state == ST_BCTAG);

    // a matching line is only accessible by stores; anything else must hit
    stallMiss  = busy & lkValid & (status.lineMatch ? ~lkIsStore : ~lkHit);
    stallDep   = status.pendLoad & status.depMatch & ~strobe.critBeat;
    memReq     = strobe.captureMiss;
    wbValid    = strobe.critBeat & status.pendLoad;
    fillWrEn   = strobe.beatTake;
    tagWrEn    = strobe.lastBeat | strobe.bcInstall;
    victimWbEn = (state == ST_BCWB) & status.vicDirty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobe.captureMiss) begin
            state   <= ST_FILL;
            beatCnt <= '0;
          end else if (strobe.captureBc) begin
            state <= ST_BCWB;
          end
        end
        ST_FILL: begin
          if (strobe.beatTake) begin
            beatCnt <= beatCnt + 1'b1;
            if (strobe.lastBeat) state <= ST_IDLE;
          end
        end
        ST_BCWB:  state <= ST_BCTAG;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted fetch opens a fill at the first beat
  p_req_opens_fill_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> (state == ST_FILL) && (beatCnt == '0));

  // R10: victim write-back is followed by the tag install
  p_victim_then_tag_r10: assert property (@(posedge clk) disable iff (!rstN)
    victimWbEn |=> tagWrEn);

  // R12: after a tag install the block is free for a new miss
  p_tag_frees_r12: assert property (@(posedge clk) disable iff (!rstN)
    tagWrEn |=> (state == ST_IDLE));

  // R8: no dependence stall survives outside a fill
  p_dep_only_fill_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_FILL) |-> !stallDep);

  // R4: two fetches never overlap
  p_one_miss_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL) |-> !memReq);

endmodule

// File: rtl/nbmiss_datapath.sv
module nbmiss_datapath
  import nbmiss_pkg::*;
#(
  parameter int LINE_W  = 26,
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2,
  parameter int BEATS   = 4,
  parameter int BEAT_W  = 64,
  parameter int WORD_W  = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic [LINE_W-1:0] lkLine,
  input  logic [$clog2(BEATS*(BEAT_W/WORD_W))-1:0] lkWord,
  input  logic [REG_W-1:0] lkDest,
  input  logic lkIsStore,
  input  logic lkVictimDirty,
  input  logic [NUM_SRC-1:0] srcValid,
  input  logic [NUM_SRC*REG_W-1:0] srcRegs,
  input  logic [BEAT_W-1:0] fillData,
  input  mhStrobe_t strobe,
  input  logic [$clog2(BEATS)-1:0] beatCnt,
  output mhStatus_t status,
  output logic [LINE_W-1:0] memReqLine,
  output logic [$clog2(BEATS)-1:0] memReqBeat,
  output logic [REG_W-1:0] wbReg,
  output logic [WORD_W-1:0] wbData,
  output logic [LINE_W-1:0] fillWrLine,
  output logic [$clog2(BEATS)-1:0] fillWrBeat,
  output logic [BEAT_W-1:0] fillWrData,
  output logic [BEAT_W/WORD_W-1:0] fillWrMask,
  output logic [LINE_W-1:0] tagWrLine,
  output logic tagWrDirty
);

  localparam int WPB        = BEAT_W / WORD_W;
  localparam int WPB_LOG    = $clog2(WPB);
  localparam int WORDS      = BEATS * WPB;
  localparam int WORD_IDX_W = $clog2(WORDS);
  localparam int BEAT_IDX_W = $clog2(BEATS);

  logic [LINE_W-1:0]     missLine;
  logic [WORD_IDX_W-1:0] critWord;
  logic [REG_W-1:0]      destReg;
  logic                  pendLoad;
  logic                  vicDirty;
  logic [WORDS-1:0]      written;
  logic [WORDS-1:0]      writtenNext;
  logic [BEAT_IDX_W-1:0] beatIdx;
  logic [NUM_SRC-1:0]    srcHit;

  // issue source compare, one comparator per read port
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign srcHit[g] = srcValid[g] && (srcRegs[g*REG_W +: REG_W] == destReg);
  end

  assign beatIdx = critWord[WORD_IDX_W-1:WPB_LOG] + beatCnt;

  always_comb begin
    status.lineMatch = (lkLine == missLine);
    status.depMatch  = |srcHit;
    status.pendLoad  = pendLoad;
    status.vicDirty  = vicDirty;
  end

  always_comb begin
    writtenNext = written;
    if (strobe.captureMiss) begin
      writtenNext = '0;
      writtenNext[lkWord] = lkIsStore;
    end else if (strobe.captureBc) begin
      writtenNext = '0;
    end else if (strobe.markStore) begin
      writtenNext[lkWord] = 1'b1;
    end
  end

  // fill write enables: a word written by a store keeps its newer data
  always_comb begin
    for (int j = 0; j < WPB; j++) begin
      logic [WORD_IDX_W-1:0] wIdx;
      wIdx = {beatIdx, WPB_LOG'(j)};
      fillWrMask[j] = ~(written[wIdx] | (strobe.markStore & (lkWord == wIdx)));
    end
  end

  always_comb begin
    memReqLine = lkLine;
    memReqBeat = lkWord[WORD_IDX_W-1:WPB_LOG];
    wbReg      = destReg;
    wbData     = fillData[critWord[WPB_LOG-1:0]*WORD_W +: WORD_W];
    fillWrLine = missLine;
    fillWrBeat = beatIdx;
    fillWrData = fillData;
    tagWrLine  = missLine;
    tagWrDirty = strobe.bcInstall | (|written) | strobe.markStore;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      missLine <= '0;
      critWord <= '0;
      destReg  <= '0;
      pendLoad <= 1'b0;
      vicDirty <= 1'b0;
      written  <= '0;
    end else begin
      written <= writtenNext;
      if (strobe.captureMiss) begin
        missLine <= lkLine;
        critWord <= lkWord;
        destReg  <= lkDest;
        pendLoad <= ~lkIsStore;
      end else if (strobe.captureBc) begin
        missLine <= lkLine;
        vicDirty <= lkVictimDirty;
        pendLoad <= 1'b0;
      end else if (strobe.critBeat) begin
        pendLoad <= 1'b0;
      end
    end
  end

  // R5: written flags never drop during an outstanding miss
  p_written_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.captureMiss || strobe.captureBc) |=> ((written & $past(written)) == $past(written)));

  // R8: the critical beat releases the pending load
  p_crit_releases_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.critBeat |=> !pendLoad);

  // R11: a store miss never leaves a load pending
  p_store_miss_no_pend_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureMiss && lkIsStore) |=> !pendLoad);

endmodule

// File: rtl/nbmiss_handler.sv
module nbmiss_handler
  import nbmiss_pkg::*;
#(
  parameter int LINE_W  = 26,
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2,
  parameter int BEATS   = 4,
  parameter int BEAT_W  = 64,
  parameter int WORD_W  = 32,
  localparam int WPB        = BEAT_W / WORD_W,
  localparam int WORD_IDX_W = $clog2(BEATS * WPB),
  localparam int BEAT_IDX_W = $clog2(BEATS)
) (
  input  logic clk,
  input  logic rstN,
  input  logic lkValid,
  input  logic lkIsStore,
  input  logic lkHit,
  input  logic lkBlockCopy,
  input  logic lkVictimDirty,
  input  logic [LINE_W-1:0] lkLine,
  input  logic [WORD_IDX_W-1:0] lkWord,
  input  logic [REG_W-1:0] lkDest,
  input  logic [NUM_SRC-1:0] srcValid,
  input  logic [NUM_SRC*REG_W-1:0] srcRegs,
  input  logic fillValid,
  input  logic [BEAT_W-1:0] fillData,
  output logic stallMiss,
  output logic stallDep,
  output logic memReq,
  output logic [LINE_W-1:0] memReqLine,
  output logic [BEAT_IDX_W-1:0] memReqBeat,
  output logic wbValid,
  output logic [REG_W-1:0] wbReg,
  output logic [WORD_W-1:0] wbData,
  output logic fillWrEn,
  output logic [LINE_W-1:0] fillWrLine,
  output logic [BEAT_IDX_W-1:0] fillWrBeat,
  output logic [BEAT_W-1:0] fillWrData,
  output logic [WPB-1:0] fillWrMask,
  output logic tagWrEn,
  output logic [LINE_W-1:0] tagWrLine,
  output logic tagWrDirty,
  output logic victimWbEn
);

  mhStrobe_t strobe;
  mhStatus_t status;
  logic [BEAT_IDX_W-1:0] beatCnt;

  nbmiss_ctrl #(.BEATS(BEATS)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkIsStore(lkIsStore), .lkHit(lkHit),
    .lkBlockCopy(lkBlockCopy), .fillValid(fillValid),
    .status(status), .strobe(strobe), .beatCnt(beatCnt),
    .stallMiss(stallMiss), .stallDep(stallDep), .memReq(memReq),
    .wbValid(wbValid), .fillWrEn(fillWrEn), .tagWrEn(tagWrEn),
    .victimWbEn(victimWbEn)
  );

  nbmiss_datapath #(
    .LINE_W(LINE_W), .REG_W(REG_W), .NUM_SRC(NUM_SRC),
    .BEATS(BEATS), .BEAT_W(BEAT_W), .WORD_W(WORD_W)
  ) i_dp (
    .clk(clk), .rstN(rstN),
    .lkLine(lkLine), .lkWord(lkWord), .lkDest(lkDest),
    .lkIsStore(lkIsStore), .lkVictimDirty(lkVictimDirty),
    .srcValid(srcValid), .srcRegs(srcRegs), .fillData(fillData),
    .strobe(strobe), .beatCnt(beatCnt), .status(status),
    .memReqLine(memReqLine), .memReqBeat(memReqBeat),
    .wbReg(wbReg), .wbData(wbData),
    .fillWrLine(fillWrLine), .fillWrBeat(fillWrBeat),
    .fillWrData(fillWrData), .fillWrMask(fillWrMask),
    .tagWrLine(tagWrLine), .tagWrDirty(tagWrDirty)
  );

endmodule

// File: tb/test_nbmiss_handler.sv
module test_nbmiss_handler;

  localparam int LW = 26;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid, lkIsStore, lkHit, lkBlockCopy, lkVictimDirty;
  logic [LW-1:0] lkLine;
  logic [2:0] lkWord;
  logic [RW-1:0] lkDest;
  logic [1:0] srcValid;
  logic [2*RW-1:0] srcRegs;
  logic fillValid;
  logic [63:0] fillData;
  logic stallMiss, stallDep, memReq, wbValid, fillWrEn, tagWrEn, tagWrDirty, victimWbEn;
  logic [LW-1:0] memReqLine, fillWrLine, tagWrLine;
  logic [1:0] memReqBeat, fillWrBeat, fillWrMask;
  logic [RW-1:0] wbReg;
  logic [31:0] wbData;
  logic [63:0] fillWrData;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nbmiss_handler i_nbmiss_handler (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkIsStore(lkIsStore), .lkHit(lkHit),
    .lkBlockCopy(lkBlockCopy), .lkVictimDirty(lkVictimDirty), .lkLine(lkLine),
    .lkWord(lkWord), .lkDest(lkDest), .srcValid(srcValid), .srcRegs(srcRegs),
    .fillValid(fillValid), .fillData(fillData), .stallMiss(stallMiss), .stallDep(stallDep),
    .memReq(memReq), .memReqLine(memReqLine), .memReqBeat(memReqBeat), .wbValid(wbValid),
    .wbReg(wbReg), .wbData(wbData), .fillWrEn(fillWrEn), .fillWrLine(fillWrLine),
    .fillWrBeat(fillWrBeat), .fillWrData(fillWrData), .fillWrMask(fillWrMask),
    .tagWrEn(tagWrEn), .tagWrLine(tagWrLine), .tagWrDirty(tagWrDirty), .victimWbEn(victimWbEn)
  );

  task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mSt;            // 0 idle, 1 filling, 2 victim step, 3 tag step
  logic [LW-1:0] mLine;
  logic [2:0] mCw;
  logic [RW-1:0] mDest;
  bit mPend, mVd;
  logic [7:0] mWr;
  int mCnt;

  always @(negedge clk) begin
    bit busy, match, stNow, beatNow, crit, last, depHit, eStallM, eStallD, eReq, isBc;
    int bIdx;
    logic [1:0] eMask;
    if (!rstN) begin
      mSt = 0; mLine = '0; mCw = '0; mDest = '0; mPend = 0; mVd = 0; mWr = '0; mCnt = 0;
    end
    busy    = (mSt != 0);
    match   = busy && (lkLine == mLine);
    isBc    = lkIsStore && lkBlockCopy;
    eStallM = lkValid && busy && (match ? !lkIsStore : !lkHit);
    stNow   = lkValid && busy && match && lkIsStore;
    beatNow = (mSt == 1) && fillValid;
    crit    = beatNow && (mCnt == 0);
    last    = beatNow && (mCnt == 3);
    bIdx    = (mCw / 2 + mCnt) % 4;
    depHit  = (srcValid[0] && srcRegs[4:0] == mDest) || (srcValid[1] && srcRegs[9:5] == mDest);
    eStallD = mPend && depHit && !crit;
    eReq    = (mSt == 0) && lkValid && !lkHit && !isBc;
    for (int j = 0; j < 2; j++)
      eMask[j] = !(mWr[bIdx*2+j] || (stNow && lkWord == 3'(bIdx*2+j)));

    cmp("R4 stallMiss", 64'(stallMiss), 64'(eStallM));
    cmp("R8 stallDep", 64'(stallDep), 64'(eStallD));
    cmp("R2 memReq", 64'(memReq), 64'(eReq));
    if (eReq) begin
      cmp("R2 memReqLine", 64'(memReqLine), 64'(lkLine));
      cmp("R2 memReqBeat", 64'(memReqBeat), 64'(lkWord / 2));
    end
    cmp("R8 wbValid", 64'(wbValid), 64'(mPend && crit));
    if (mPend && crit) begin
      cmp("R8 wbReg", 64'(wbReg), 64'(mDest));
      cmp("R8 wbData", 64'(wbData), mCw[0] ? 64'(fillData[63:32]) : 64'(fillData[31:0]));
    end
    cmp("R6 fillWrEn", 64'(fillWrEn), 64'(beatNow));
    if (beatNow) begin
      cmp("R6 fillWrLine", 64'(fillWrLine), 64'(mLine));
      cmp("R6 fillWrBeat", 64'(fillWrBeat), 64'(bIdx));
      cmp("R6 fillWrData", fillWrData, fillData);
      cmp("R7 fillWrMask", 64'(fillWrMask), 64'(eMask));
    end
    cmp("R9 tagWrEn", 64'(tagWrEn), 64'(last || mSt == 3));
    if (last) begin
      cmp("R9 tagWrLine", 64'(tagWrLine), 64'(mLine));
      cmp("R9 tagWrDirty", 64'(tagWrDirty), 64'((mWr != 0) || stNow));
    end
    if (mSt == 3) begin
      cmp("R10 tagWrLine", 64'(tagWrLine), 64'(mLine));
      cmp("R10 tagWrDirty", 64'(tagWrDirty), 64'(1));
    end
    cmp("R10 victimWbEn", 64'(victimWbEn), 64'(mSt == 2 && mVd));

    if (rstN) begin
      case (mSt)
        0: if (lkValid && !lkHit) begin
             mLine = lkLine;
             mWr = '0;
             if (isBc) begin
               mSt = 2; mVd = lkVictimDirty; mPend = 0;
             end else begin
               mSt = 1; mCw = lkWord; mDest = lkDest; mPend = !lkIsStore; mCnt = 0;
               if (lkIsStore) mWr[lkWord] = 1'b1;
             end
           end
        1: begin
             if (stNow) mWr[lkWord] = 1'b1;
             if (beatNow) begin
               if (crit) mPend = 0;
               if (last) mSt = 0;
               mCnt = (mCnt + 1) % 4;
             end
           end
        2: begin
             if (stNow) mWr[lkWord] = 1'b1;
             mSt = 3;
           end
        default: mSt = 0;
      endcase
    end
  end

  // ---------------- stimulus ----------------
  task automatic clr();
    lkValid = 0; lkIsStore = 0; lkHit = 0; lkBlockCopy = 0; lkVictimDirty = 0;
    lkLine = '0; lkWord = '0; lkDest = '0; srcValid = '0; srcRegs = '0;
    fillValid = 0; fillData = '0;
  endtask

  task automatic look(bit st, bit hit, logic [LW-1:0] line, logic [2:0] w, logic [RW-1:0] d,
                      bit bc = 0, bit vd = 0);
    lkValid = 1; lkIsStore = st; lkHit = hit; lkLine = line; lkWord = w; lkDest = d;
    lkBlockCopy = bc; lkVictimDirty = vd;
  endtask

  task automatic beat(logic [63:0] d);
    fillValid = 1; fillData = d;
  endtask

  task automatic src(int port, logic [RW-1:0] r);
    srcValid[port] = 1'b1;
    srcRegs[port*RW +: RW] = r;
  endtask

  task automatic tick();
    @(posedge clk); #1; clr();
  endtask

  task automatic chk(string tag, bit ok);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0 expected=1 at %0t", tag, $time);
    end
  endtask

  initial begin
    clr();
    #9;
    chk("R1 quiet in reset", !stallMiss && !stallDep && !memReq && !wbValid &&
        !fillWrEn && !tagWrEn && !victimWbEn);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #3;
    chk("R1 quiet after reset", !stallMiss && !stallDep && !memReq && !tagWrEn && !victimWbEn);
    tick();

    // load miss, word 5, destination r7
    look(0, 0, 26'h100, 3'd5, 5'd7); #3;
    chk("R2 fetch on load miss", memReq && memReqBeat == 2'd2 && !stallMiss); tick();
    look(0, 1, 26'h222, 3'd0, 5'd3); src(0, 5'd7); #3;
    chk("R3 hit flows during fill", !stallMiss); chk("R8 dependent held", stallDep); tick();
    look(1, 0, 26'h100, 3'd4, 5'd0); #3; chk("R5 store to filling line taken", !stallMiss); tick();
    look(1, 0, 26'h100, 3'd1, 5'd0); tick();
    look(0, 0, 26'h333, 3'd0, 5'd2); src(0, 5'd7); #3; chk("R4 second miss held", stallMiss); tick();
    look(0, 0, 26'h100, 3'd2, 5'd2); src(0, 5'd7); #3; chk("R4 load to filling line held", stallMiss); tick();
    beat(64'hAAAA_0005_BBBB_0004); src(0, 5'd7); #3;
    chk("R8 release on critical word", !stallDep && wbValid && wbData == 32'hAAAA_0005);
    chk("R7 stored word masked", fillWrMask == 2'b10); tick();
    src(0, 5'd7); #3; chk("R8 no stall after return", !stallDep); tick();
    beat(64'h3333_0007_3333_0006); look(1, 0, 26'h100, 3'd6, 5'd0); #3;
    chk("R7 same-cycle store masked", fillWrMask == 2'b10); tick();
    beat(64'h0000_0001_0000_0000); tick();
    beat(64'h1111_0003_1111_0002); look(0, 0, 26'h333, 3'd0, 5'd2); #3;
    chk("R4 miss during last beat held", stallMiss); chk("R9 dirty install", tagWrEn && tagWrDirty); tick();
    look(0, 0, 26'h333, 3'd0, 5'd2); #3; chk("R12 next miss accepted", memReq && !stallMiss); tick();

    // second load miss, critical word 0, dependent on the second source port
    src(0, 5'd9); src(1, 5'd2); tick();
    src(1, 5'd2); beat(64'h5555_0001_5555_0000); #3;
    chk("R8 even word returned", wbValid && wbData == 32'h5555_0000 && wbReg == 5'd2); tick();
    beat(64'h11); tick();
    beat(64'h22); tick();
    beat(64'h33); #3; chk("R9 clean install", tagWrEn && !tagWrDirty); tick();

    // store miss on word 3
    look(1, 0, 26'h044, 3'd3, 5'd7); #3; chk("R2 fetch on store miss", memReq && memReqBeat == 2'd1); tick();
    look(0, 1, 26'h555, 3'd0, 5'd7); src(0, 5'd7); #3;
    chk("R11 store miss leaves no dependence", !stallDep && !stallMiss); tick();
    look(1, 0, 26'h555, 3'd0, 5'd0); tick();
    look(0, 0, 26'h044, 3'd2, 5'd1); #3; chk("R11 load to store-miss line held", stallMiss); tick();
    beat(64'h0303_0303_0202_0202); tick();
    beat(64'h0505_0505_0404_0404); tick();
    tick();
    beat(64'h0707_0707_0606_0606); tick();
    beat(64'h0101_0101_0000_0000); #3; chk("R9 store miss installs dirty", tagWrEn && tagWrDirty); tick();

    // block-copy store, dirty victim
    look(1, 0, 26'h0AB, 3'd0, 5'd0, 1, 1); #3; chk("R10 no fetch for block copy", !memReq); tick();
    look(0, 0, 26'h777, 3'd0, 5'd1); beat(64'hDEAD); #3;
    chk("R10 dirty victim written back", victimWbEn); chk("R6 beat ignored outside fill", !fillWrEn); tick();
    #3; chk("R10 tag installed dirty", tagWrEn && tagWrDirty && tagWrLine == 26'h0AB); tick();

    // block-copy store, clean victim
    look(1, 0, 26'h0CD, 3'd2, 5'd0, 1, 0); tick();
    #3; chk("R10 clean victim kept", !victimWbEn); tick();
    tick();

    // idle beat ignored
    beat(64'hBEEF); #3; chk("R6 idle beat ignored", !fillWrEn); tick();
    repeat (3) tick();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R12 watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule